// File: doc/BRIEF.md
# Keyboard Controller Self-Test Responder

This block is a minimal keyboard-controller stand-in on a simple register bus. It gives host firmware enough to detect the controller and run its self-test. It has no keyboard or mouse links. It decodes two byte-wide ports: a data port and a command/status port. Any one-byte write to either port is held as the current command byte.

A status read always reports the output buffer as full. A data read returns the self-test pass code only while the held command is the self-test opcode. In every other case a data read returns zero.

Each request is presented for one cycle with `req_valid`, which is a single-cycle strobe with no back-pressure. Exactly one response follows on the next cycle. Errors are flagged on `rsp_err`, and any errored response carries zero read data.

Top module: `kbc_selftest_stub`

## Requirements
- R1: After reset `rsp_valid` is low and the held command is 0x00, so a data-port read returns 0x00 until a command arrives.
- R2: Every cycle with `req_valid` high produces exactly one response, with `rsp_valid` high on the following cycle. A cycle without a request produces no response.
- R3: A read at offset 0x4 (command/status port), of any size, returns 0x01 with `rsp_err` low. Only bit 0 (output buffer full) is set.
- R4: A write with `req_size` = 0 (one byte) at offset 0x0 or 0x4 stores `req_wdata[7:0]` as the held command. Upper data bits are ignored. The new value is visible to a read issued in the very next cycle.
- R5: A read at offset 0x0 (data port) returns 0x55 when the held command is 0xAA and 0x00 for any other held value, with `rsp_err` low.
- R6: A write at offset 0x0 or 0x4 with `req_size` of 1, 2 or 3 (two, four or eight bytes) is rejected with `rsp_err` high and leaves the held command unchanged.
- R7: Reading the data port does not alter the held command, so repeated reads after a self-test command keep returning 0x55.
- R8: Any access at an offset other than 0x0 or 0x4 responds with `rsp_err` high and `rsp_rdata` = 0. A write there leaves the held command unchanged.
- R9: An accepted one-byte write responds with `rsp_err` low and `rsp_rdata` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (3) | Byte offset within the block |
| req_size | input | 2 | Access size: 0 = 1 byte, 1 = 2, 2 = 4, 3 = 8 bytes |
| req_wdata | input | DATA_W (32) | Write data; byte lane 0 is used |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_err | output | 1 | Access rejected (bad offset or wide write) |
| rsp_rdata | output | DATA_W (32) | Read data, zero-extended byte |

## Verification
The two functions that can fall in the same cycle are a command write being latched and a data-port read being decoded. A write of 0xAA or 0x00 is issued and followed without a gap by a data read. The read's reply is formed in the cycle in which the latch takes the new byte. The scoreboard predicts the reply from the newly written command, so a stale or bypassed value shows up as a mismatch. The same back-to-back pattern is used with rejected wide writes and bad-offset writes, where the read must still see the old command.

// File: rtl/kbc_pkg.sv
package kbc_pkg;

  localparam int unsigned KBC_BYTE_W = 8;

  // Port offsets; the host decodes these, so they are fixed.
  localparam logic [7:0] KBC_OFS_DATA = 8'h00;
  localparam logic [7:0] KBC_OFS_CTRL = 8'h04;

  localparam logic [7:0] KBC_OP_SELFTEST = 8'hAA;
  localparam logic [7:0] KBC_CODE_PASS   = 8'h55;
  localparam logic [7:0] KBC_STAT_OBF    = 8'h01;
  localparam logic [7:0] KBC_RESET_CMD   = 8'h00;

  typedef enum logic [1:0] {
    KBC_SZ_B1 = 2'd0,
    KBC_SZ_B2 = 2'd1,
    KBC_SZ_B4 = 2'd2,
    KBC_SZ_B8 = 2'd3
  } kbc_size_e;

  typedef struct packed {
    logic hit_data;
    logic hit_ctrl;
    logic bad_ofs;
    logic wr_ok;
    logic wr_wide;
    logic rd_data;
    logic rd_ctrl;
  } kbc_dec_t;

  // Reply byte for a data-port read given the held command.
  function automatic logic [7:0] kbc_data_reply(input logic [7:0] cmd);
    return (cmd == KBC_OP_SELFTEST) ? KBC_CODE_PASS : 8'h00;
  endfunction

  function automatic logic kbc_is_byte(input logic [1:0] sz);
    return kbc_size_e'(sz) == KBC_SZ_B1;
  endfunction

endpackage

// File: rtl/kbc_decode.sv
module kbc_decode
  import kbc_pkg::*;
#(
  parameter int unsigned ADDR_W = 3
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  output kbc_dec_t          dec
);

  localparam logic [ADDR_W-1:0] OfsData = ADDR_W'(KBC_OFS_DATA);
  localparam logic [ADDR_W-1:0] OfsCtrl = ADDR_W'(KBC_OFS_CTRL);

  logic is_byte;

  always_comb begin
    is_byte      = kbc_is_byte(req_size);
    dec.hit_data = req_valid && (req_addr == OfsData);
    dec.hit_ctrl = req_valid && (req_addr == OfsCtrl);
    dec.bad_ofs  = req_valid && !dec.hit_data && !dec.hit_ctrl;
    dec.wr_ok    = req_write && (dec.hit_data || dec.hit_ctrl) && is_byte;
    dec.wr_wide  = req_write && (dec.hit_data || dec.hit_ctrl) && !is_byte;
    dec.rd_data  = !req_write && dec.hit_data;
    dec.rd_ctrl  = !req_write && dec.hit_ctrl;
  end

endmodule

// File: rtl/kbc_cmd_latch.sv
module kbc_cmd_latch
  import kbc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       reject,
  input  logic [7:0] wbyte,
  output logic [7:0] cmd_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_q <= KBC_RESET_CMD;
    else if (load) cmd_q <= wbyte;
  end

  // R6: a rejected wide write must not disturb the held command
  a_r6_wide_keeps_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> $stable(cmd_q));

  // R4: an accepted write is held from the next cycle
  a_r4_load_takes_byte: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cmd_q == $past(wbyte)));

endmodule

// File: rtl/kbc_resp.sv
module kbc_resp
  import kbc_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  kbc_dec_t          dec,
  input  logic [7:0]        cmd_q,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata
);

  localparam int unsigned PadW = DATA_W - KBC_BYTE_W;

  logic [7:0] rd_byte;
  logic       err_d;

  always_comb begin
    rd_byte = 8'h00;
    if (dec.rd_data) rd_byte = kbc_data_reply(cmd_q);
    else if (dec.rd_ctrl) rd_byte = KBC_STAT_OBF;
    err_d = dec.bad_ofs || dec.wr_wide;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && err_d;
      rsp_rdata <= req_valid ? {{PadW{1'b0}}, rd_byte} : '0;
    end
  end

  // R2: one response per request, one cycle later
  a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  // R8: errored responses carry no data
  a_r8_err_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_rdata == '0));
  // R3: status reads report only output-buffer-full
  a_r3_status_obf: assert property (@(posedge clk) disable iff (!rst_n)
    dec.rd_ctrl |=> (rsp_rdata == DATA_W'(1) && !rsp_err));
  // R5: self-test opcode held gives pass code
  a_r5_pass_code: assert property (@(posedge clk) disable iff (!rst_n)
    (dec.rd_data && cmd_q == KBC_OP_SELFTEST) |=> (rsp_rdata == DATA_W'(8'h55)));

endmodule

// File: rtl/kbc_selftest_stub.sv
module kbc_selftest_stub
  import kbc_pkg::*;
#(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata
);

  kbc_dec_t   dec;
  logic [7:0] cmd_q;
  logic [7:0] wbyte;

  assign wbyte = req_wdata[7:0];

  kbc_decode #(.ADDR_W(ADDR_W)) u_dec (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .dec       (dec)
  );

  kbc_cmd_latch u_cmd (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (dec.wr_ok),
    .reject (dec.wr_wide || (req_write && dec.bad_ofs)),
    .wbyte  (wbyte),
    .cmd_q  (cmd_q)
  );

  kbc_resp #(.DATA_W(DATA_W)) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .dec       (dec),
    .cmd_q     (cmd_q),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_rdata (rsp_rdata)
  );

  // R9: accepted writes answer cleanly
  a_r9_write_clean: assert property (@(posedge clk) disable iff (!rst_n)
    dec.wr_ok |=> (!rsp_err && rsp_rdata == '0));
  // R8: writes at a bad offset do not reach the command byte
  a_r8_bad_write_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (req_write && dec.bad_ofs) |=> $stable(cmd_q));

endmodule

// File: tb/tb_kbc_selftest_stub.sv
module tb_kbc_selftest_stub;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [1:0]        req_size = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic              rsp_valid;
  logic              rsp_err;
  logic [DATA_W-1:0] rsp_rdata;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [7:0]        m_cmd;
  bit                q_err[$];
  logic [DATA_W-1:0] q_data[$];
  string             q_tag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  kbc_selftest_stub #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: presents one request per call and pushes the predicted reply.
  task automatic access(input bit wr, input int addr, input int size,
                        input logic [DATA_W-1:0] wd, input string tag);
    bit e;
    logic [DATA_W-1:0] d;
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = ADDR_W'(addr);
    req_size  = 2'(size);
    req_wdata = wd;
    e = 1'b0;
    d = '0;
    if (addr == 0 || addr == 4) begin
      if (wr) begin
        if (size == 0) m_cmd = wd[7:0];
        else e = 1'b1;
      end else if (addr == 0) begin
        d = (m_cmd == 8'hAA) ? 32'h55 : 32'h0;
      end else begin
        d = 32'h01;
      end
    end else begin
      e = 1'b1;
    end
    q_err.push_back(e);
    q_data.push_back(d);
    q_tag.push_back(tag);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    req_valid = 1'b0;
    req_write = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pops and compares each response.
  always @(negedge clk) begin
    if (rst_n && !done && rsp_valid) begin
      if (q_tag.size() == 0) begin
        check(1'b0, "R2 unexpected response", 64'(rsp_rdata), 64'h0);
      end else begin
        automatic bit e = q_err.pop_front();
        automatic logic [DATA_W-1:0] d = q_data.pop_front();
        automatic string t = q_tag.pop_front();
        check(rsp_err == e, {t, " err"}, 64'(rsp_err), 64'(e));
        check(rsp_rdata == d, {t, " data"}, 64'(rsp_rdata), 64'(d));
      end
    end
  end

  initial begin
    m_cmd = 8'h00;
    repeat (3) @(negedge clk);
    check(rsp_valid == 1'b0, "R1 rsp_valid in reset", 64'(rsp_valid), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(rsp_valid == 1'b0, "R1 rsp_valid after reset", 64'(rsp_valid), 64'h0);

    access(0, 0, 0, '0, "R1 data read after reset");
    idle(1);
    access(0, 4, 0, '0, "R3 status read byte");
    access(0, 4, 2, '0, "R3 status read word");
    idle(1);
    access(1, 4, 0, 32'hAA, "R9 selftest write ctrl");
    access(0, 0, 0, '0, "R4 R5 pass code back-to-back");
    access(0, 0, 0, '0, "R7 repeat read 1");
    access(0, 0, 1, '0, "R7 repeat read 2");
    idle(2);
    access(1, 0, 0, 32'hAB, "R9 write data port");
    access(0, 0, 0, '0, "R5 non-selftest gives zero");
    access(1, 0, 0, 32'hAA, "R4 write data port");
    idle(1);
    access(0, 0, 0, '0, "R4 data port store");
    access(1, 4, 1, 32'h00, "R6 halfword write rejected");
    access(0, 0, 0, '0, "R6 command unchanged after halfword");
    access(1, 0, 2, 32'h00, "R6 word write rejected");
    access(1, 4, 3, 32'h00, "R6 dword write rejected");
    access(0, 0, 0, '0, "R6 command unchanged after wide");
    access(1, 2, 0, 32'h11, "R8 write bad offset");
    access(0, 7, 0, '0, "R8 read bad offset");
    access(0, 1, 0, '0, "R8 read offset 1");
    access(0, 0, 0, '0, "R8 command unchanged");
    access(1, 0, 0, 32'h00, "R4 clear command");
    access(0, 0, 0, '0, "R4 cleared back-to-back");
    access(1, 4, 0, 32'h123456AA, "R4 upper bits ignored");
    access(0, 0, 0, '0, "R4 upper bits pass code");
    idle(3);
    check(q_tag.size() == 0, "R2 all responses seen", 64'(q_tag.size()), 64'h0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      check(1'b0, "R2 watchdog expired", 64'h1, 64'h0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule